// File: doc/BRIEF.md
# Receive Data-Ready and Clock Gating Sequencer

This block follows a receive frame through its phases and decides, cycle by cycle, whether the receive data clock runs, whether the data-ready flag is up, and whether the header rate or the payload rate is selected. Its inputs are single-cycle events from the demodulator: tracking has begun, the start-frame delimiter was found, the header has been shifted out, the header CRC passed or failed, and the payload has ended. It also enables the transmit data clock when a transmit burst starts.

Two configuration bits change the timing. One moves the rise of data-ready from delimiter detection to the start of the payload, after the header CRC has passed. The other replaces gated clocks, which stop while the header CRC is checked, with a receive clock that runs without a break from tracking start. Free-running clocks are honoured only at the two lowest rate codes. Configuration is captured only while both transmit enable and receive enable are low, so it cannot change in the middle of a frame.

Top module: `frame_clk_seq`

## Requirements
- R1: After reset, rx_clk_en, tx_clk_en and data_rdy are 0 and hdr_rate_sel is 1; the captured configuration is gated clocks, early ready and rate code 0.
- R2: With early ready (cfg_late_rdy captured as 0), data_rdy is 1 from the cycle after sfd_det through the header, the CRC wait and the payload, and returns to 0 the cycle after payload_end.
- R3: With late ready (cfg_late_rdy captured as 1), data_rdy stays 0 through the header and the CRC wait and rises the cycle after crc_ok.
- R4: With gated clocks, rx_clk_en is 1 from the cycle after sfd_det until the cycle after hdr_done, is 0 while the CRC result is awaited, and is 1 again from the cycle after crc_ok until the cycle after payload_end.
- R5: With free-running clocks, rx_clk_en is 1 from the cycle after trk_start without a gap through the CRC wait, until a header failure, payload_end or rx_en low.
- R6: crc_bad while the CRC result is awaited clears data_rdy and rx_clk_en in the next cycle and returns to idle; delimiter, header and CRC events in idle are ignored until the next trk_start.
- R7: rx_en low returns the sequencer to idle in the next cycle from any phase, with data_rdy and rx_clk_en 0; receive events are ignored while rx_en is low.
- R8: hdr_rate_sel is 0 (payload rate) exactly while the payload is being received, from the cycle after crc_ok until the cycle after payload_end, and 1 otherwise.
- R9: With gated clocks, tx_clk_en rises the cycle after tx_ready is seen while tx_en is 1, stays 1 while tx_en is 1 even after tx_ready falls, and is 0 the cycle after tx_en goes low.
- R10: With free-running clocks, tx_clk_en rises the cycle after tx_en rises, without waiting for tx_ready.
- R11: cfg_free_run takes effect only at rate codes 0 and 1 (the two lowest rates); at rate codes 2 and 3 the block behaves as with gated clocks.
- R12: cfg_late_rdy, cfg_free_run and cfg_rate are captured on a clock edge only when tx_en and rx_en are both 0; changes while either is 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable |
| tx_en | input | 1 | Transmit enable |
| tx_ready | input | 1 | Transmitter ready to take data |
| trk_start | input | 1 | Pulse: demodulator started tracking |
| sfd_det | input | 1 | Pulse: start-frame delimiter found |
| hdr_done | input | 1 | Pulse: last header field shifted out |
| crc_ok | input | 1 | Pulse: header CRC passed |
| crc_bad | input | 1 | Pulse: header CRC failed |
| payload_end | input | 1 | Pulse: last payload bit delivered |
| cfg_late_rdy | input | 1 | 1 = data-ready after header CRC, 0 = after delimiter |
| cfg_free_run | input | 1 | 1 = free-running data clocks, 0 = gated |
| cfg_rate | input | RATE_W | Rate code, 0 lowest |
| rx_clk_en | output | 1 | Receive data clock enable |
| tx_clk_en | output | 1 | Transmit data clock enable |
| data_rdy | output | 1 | Data-ready flag |
| hdr_rate_sel | output | 1 | 1 = header rate, 0 = payload rate |

## Verification
The bench aims at the gap in the receive clock during the CRC wait: a design that forgot it would keep clocking data while the header is checked, and one that applied it in free-running mode would drop clock edges there. It checks the late-ready setting, where a wrong design would raise data-ready on the delimiter, and a failed header followed by a stray delimiter, where a design that did not return to idle would restart the clock. It changes the configuration mid-frame and sets free running at a high rate code, where a design that captured too eagerly or ignored the rate limit would switch clock modes.

// File: rtl/frame_clk_pkg.sv
package frame_clk_pkg;

  parameter int RATE_W = 2;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_TRACK = 3'd1,
    PH_HDR   = 3'd2,
    PH_CRC   = 3'd3,
    PH_DATA  = 3'd4
  } phase_t;

  typedef struct packed {
    logic              late_rdy;
    logic              free_run;
    logic [RATE_W-1:0] rate;
  } seq_cfg_t;

  // Free running honoured only up to a maximum rate code.
  function automatic logic free_allowed(input seq_cfg_t c, input int max_rate);
    return c.free_run && (int'(c.rate) <= max_rate);
  endfunction

  function automatic logic rx_clk_on(input phase_t ph, input logic free_eff);
    if (free_eff) return ph != PH_IDLE;
    return (ph == PH_HDR) || (ph == PH_DATA);
  endfunction

  function automatic logic ready_on(input phase_t ph, input logic late);
    if (late) return ph == PH_DATA;
    return (ph == PH_HDR) || (ph == PH_CRC) || (ph == PH_DATA);
  endfunction

endpackage

// File: rtl/fcs_cfg_hold.sv
module fcs_cfg_hold
  import frame_clk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              tx_en,
  input  logic              late_in,
  input  logic              free_in,
  input  logic [RATE_W-1:0] rate_in,
  output seq_cfg_t          cfg_q
);

  logic open_win;
  assign open_win = !rx_en && !tx_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (open_win) begin
      cfg_q.late_rdy <= late_in;
      cfg_q.free_run <= free_in;
      cfg_q.rate     <= rate_in;
    end
  end

  a_r12_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en || tx_en) |=> $stable(cfg_q));

endmodule

// File: rtl/fcs_rx_fsm.sv
module fcs_rx_fsm
  import frame_clk_pkg::*;
#(
  parameter int FREE_MAX_RATE = 1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rx_en,
  input  logic     trk_start,
  input  logic     sfd_det,
  input  logic     hdr_done,
  input  logic     crc_ok,
  input  logic     crc_bad,
  input  logic     payload_end,
  input  seq_cfg_t cfg,
  output logic     rx_clk_en,
  output logic     data_rdy,
  output logic     hdr_rate_sel
);

  phase_t ph_q, ph_d;
  logic   free_eff;
  logic   ev_hdr_fail;
  logic   ev_payload_go;

  assign free_eff      = free_allowed(cfg, FREE_MAX_RATE);
  assign ev_hdr_fail   = rx_en && (ph_q == PH_CRC) && crc_bad;
  assign ev_payload_go = rx_en && (ph_q == PH_CRC) && crc_ok;

  always_comb begin
    ph_d = ph_q;
    if (!rx_en) begin
      ph_d = PH_IDLE;
    end else begin
      unique case (ph_q)
        PH_IDLE:  if (trk_start)   ph_d = PH_TRACK;
        PH_TRACK: if (sfd_det)     ph_d = PH_HDR;
        PH_HDR:   if (hdr_done)    ph_d = PH_CRC;
        PH_CRC: begin
          if (ev_payload_go)       ph_d = PH_DATA;
          else if (ev_hdr_fail)    ph_d = PH_IDLE;
        end
        PH_DATA:  if (payload_end) ph_d = PH_IDLE;
        default:                   ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  assign rx_clk_en    = rx_clk_on(ph_q, free_eff);
  assign data_rdy     = ready_on(ph_q, cfg.late_rdy);
  assign hdr_rate_sel = (ph_q != PH_DATA);

  a_r6_fail_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hdr_fail |=> (!data_rdy && !rx_clk_en));

  a_r7_rx_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!data_rdy && !rx_clk_en && hdr_rate_sel));

  a_r3_late_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.late_rdy && $rose(data_rdy)) |-> $past(ev_payload_go));

  a_r8_payload_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_rate_sel |-> (data_rdy && rx_clk_en));

  a_r4_crc_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (!free_eff && (ph_q == PH_CRC)) |-> !rx_clk_en);

endmodule

// File: rtl/fcs_tx_gate.sv
module fcs_tx_gate
  import frame_clk_pkg::*;
#(
  parameter int FREE_MAX_RATE = 1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tx_en,
  input  logic     tx_ready,
  input  seq_cfg_t cfg,
  output logic     tx_clk_en
);

  logic run_q;
  logic free_eff;
  logic start_ev;

  assign free_eff = free_allowed(cfg, FREE_MAX_RATE);
  assign start_ev = free_eff || tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)        run_q <= 1'b0;
    else if (!tx_en)   run_q <= 1'b0;
    else if (start_ev) run_q <= 1'b1;
  end

  assign tx_clk_en = run_q;

  a_r9_tx_off: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !tx_clk_en);

  a_r9_tx_gated_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!free_eff && $rose(tx_clk_en)) |-> $past(tx_ready && tx_en));

endmodule

// File: rtl/frame_clk_seq.sv
module frame_clk_seq
  import frame_clk_pkg::*;
#(
  parameter int FREE_MAX_RATE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              tx_en,
  input  logic              tx_ready,
  input  logic              trk_start,
  input  logic              sfd_det,
  input  logic              hdr_done,
  input  logic              crc_ok,
  input  logic              crc_bad,
  input  logic              payload_end,
  input  logic              cfg_late_rdy,
  input  logic              cfg_free_run,
  input  logic [RATE_W-1:0] cfg_rate,
  output logic              rx_clk_en,
  output logic              tx_clk_en,
  output logic              data_rdy,
  output logic              hdr_rate_sel
);

  seq_cfg_t cfg_q;

  fcs_cfg_hold u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_en   (rx_en),
    .tx_en   (tx_en),
    .late_in (cfg_late_rdy),
    .free_in (cfg_free_run),
    .rate_in (cfg_rate),
    .cfg_q   (cfg_q)
  );

  fcs_rx_fsm #(.FREE_MAX_RATE(FREE_MAX_RATE)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_en        (rx_en),
    .trk_start    (trk_start),
    .sfd_det      (sfd_det),
    .hdr_done     (hdr_done),
    .crc_ok       (crc_ok),
    .crc_bad      (crc_bad),
    .payload_end  (payload_end),
    .cfg          (cfg_q),
    .rx_clk_en    (rx_clk_en),
    .data_rdy     (data_rdy),
    .hdr_rate_sel (hdr_rate_sel)
  );

  fcs_tx_gate #(.FREE_MAX_RATE(FREE_MAX_RATE)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .tx_ready  (tx_ready),
    .cfg       (cfg_q),
    .tx_clk_en (tx_clk_en)
  );

endmodule

// File: tb/frame_clk_seq_tb_top.sv
module frame_clk_seq_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 0, tx_en = 0, tx_ready = 0;
  logic trk_start = 0, sfd_det = 0, hdr_done = 0;
  logic crc_ok = 0, crc_bad = 0, payload_end = 0;
  logic cfg_late_rdy = 0, cfg_free_run = 0;
  logic [1:0] cfg_rate = 2'd0;
  logic rx_clk_en, tx_clk_en, data_rdy, hdr_rate_sel;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  frame_clk_seq dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_en(tx_en), .tx_ready(tx_ready),
    .trk_start(trk_start), .sfd_det(sfd_det), .hdr_done(hdr_done),
    .crc_ok(crc_ok), .crc_bad(crc_bad), .payload_end(payload_end),
    .cfg_late_rdy(cfg_late_rdy), .cfg_free_run(cfg_free_run), .cfg_rate(cfg_rate),
    .rx_clk_en(rx_clk_en), .tx_clk_en(tx_clk_en), .data_rdy(data_rdy),
    .hdr_rate_sel(hdr_rate_sel)
  );

  // Behavioural reference: phase as a small integer (0 idle, 1 tracking,
  // 2 header, 3 awaiting CRC, 4 payload).
  int m_phase = 0;
  bit m_late = 0, m_free = 0, m_tx = 0;
  int m_rate = 0;

  function automatic bit m_free_eff();
    return m_free && (m_rate < 2);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_late = 0; m_free = 0; m_rate = 0; m_tx = 0;
    end else begin
      if (!tx_en) m_tx = 0;
      else if (m_free_eff() || tx_ready) m_tx = 1;
      if (!rx_en) m_phase = 0;
      else if (m_phase == 0 && trk_start) m_phase = 1;
      else if (m_phase == 1 && sfd_det) m_phase = 2;
      else if (m_phase == 2 && hdr_done) m_phase = 3;
      else if (m_phase == 3 && crc_ok) m_phase = 4;
      else if (m_phase == 3 && crc_bad) m_phase = 0;
      else if (m_phase == 4 && payload_end) m_phase = 0;
      if (!tx_en && !rx_en) begin
        m_late = cfg_late_rdy; m_free = cfg_free_run; m_rate = int'(cfg_rate);
      end
    end
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the reference.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_rx;
      e_rx = m_free_eff() ? (m_phase != 0) : (m_phase == 2 || m_phase == 4);
      check(cur_req, "rx_clk_en", rx_clk_en, e_rx);
      check(cur_req, "data_rdy", data_rdy, m_late ? (m_phase == 4) : (m_phase >= 2));
      check(cur_req, "hdr_rate_sel", hdr_rate_sel, m_phase != 4);
      check(cur_req, "tx_clk_en", tx_clk_en, m_tx);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input bit late, input bit free, input bit [1:0] rate);
    rx_en = 0; tx_en = 0;
    cfg_late_rdy = late; cfg_free_run = free; cfg_rate = rate;
    tick(2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // R1 reset state
    check("R1", "rx_clk_en", rx_clk_en, 0);
    check("R1", "tx_clk_en", tx_clk_en, 0);
    check("R1", "data_rdy", data_rdy, 0);
    check("R1", "hdr_rate_sel", hdr_rate_sel, 1);

    // R2 R4 R8: early ready, gated clocks, high rate
    cur_req = "R2";
    set_cfg(0, 0, 2'd3);
    rx_en = 1; tick(2);
    trk_start = 1; tick(1); trk_start = 0;
    check("R4", "rx_clk_en in tracking", rx_clk_en, 0);
    tick(2);
    sfd_det = 1; tick(1); sfd_det = 0;
    check("R2", "data_rdy after sfd", data_rdy, 1);
    check("R4", "rx_clk_en in header", rx_clk_en, 1);
    tick(3);
    hdr_done = 1; tick(1); hdr_done = 0;
    cur_req = "R4";
    check("R4", "rx_clk_en during CRC wait", rx_clk_en, 0);
    check("R2", "data_rdy during CRC wait", data_rdy, 1);
    tick(2);
    crc_ok = 1; tick(1); crc_ok = 0;
    check("R4", "rx_clk_en in payload", rx_clk_en, 1);
    check("R8", "hdr_rate_sel in payload", hdr_rate_sel, 0);
    tick(4);
    payload_end = 1; tick(1); payload_end = 0;
    check("R2", "data_rdy after end", data_rdy, 0);
    check("R8", "hdr_rate_sel after end", hdr_rate_sel, 1);

    // R3 late ready
    cur_req = "R3";
    set_cfg(1, 0, 2'd1);
    rx_en = 1; tick(1);
    trk_start = 1; tick(1); trk_start = 0; tick(1);
    sfd_det = 1; tick(1); sfd_det = 0;
    check("R3", "data_rdy in header", data_rdy, 0);
    tick(2);
    hdr_done = 1; tick(1); hdr_done = 0;
    check("R3", "data_rdy in CRC wait", data_rdy, 0);
    crc_ok = 1; tick(1); crc_ok = 0;
    check("R3", "data_rdy after crc_ok", data_rdy, 1);
    tick(2);
    payload_end = 1; tick(1); payload_end = 0;

    // R5 R6 free running at rate 0, header failure
    cur_req = "R5";
    set_cfg(0, 1, 2'd0);
    rx_en = 1; tick(1);
    trk_start = 1; tick(1); trk_start = 0;
    check("R5", "rx_clk_en after tracking", rx_clk_en, 1);
    tick(2);
    sfd_det = 1; tick(1); sfd_det = 0; tick(1);
    hdr_done = 1; tick(1); hdr_done = 0;
    check("R5", "rx_clk_en through CRC wait", rx_clk_en, 1);
    cur_req = "R6";
    crc_bad = 1; tick(1); crc_bad = 0;
    check("R6", "rx_clk_en after crc_bad", rx_clk_en, 0);
    check("R6", "data_rdy after crc_bad", data_rdy, 0);
    sfd_det = 1; tick(1); sfd_det = 0;
    check("R6", "stray sfd in idle", data_rdy, 0);
    crc_ok = 1; tick(1); crc_ok = 0;
    check("R6", "stray crc_ok in idle", hdr_rate_sel, 1);

    // R7 rx_en low mid payload
    cur_req = "R7";
    trk_start = 1; tick(1); trk_start = 0;
    sfd_det = 1; tick(1); sfd_det = 0;
    hdr_done = 1; tick(1); hdr_done = 0;
    crc_ok = 1; tick(1); crc_ok = 0;
    check("R7", "payload reached", hdr_rate_sel, 0);
    rx_en = 0; tick(1);
    check("R7", "rx_clk_en after rx_en low", rx_clk_en, 0);
    check("R7", "hdr_rate_sel after rx_en low", hdr_rate_sel, 1);
    trk_start = 1; tick(1); trk_start = 0;
    check("R7", "trk_start ignored while rx_en low", rx_clk_en, 0);

    // R11 free run requested at high rate behaves gated
    cur_req = "R11";
    set_cfg(0, 1, 2'd3);
    rx_en = 1; tick(1);
    trk_start = 1; tick(1); trk_start = 0;
    check("R11", "no clock in tracking at rate 3", rx_clk_en, 0);

    // R12 configuration changes while rx_en high are ignored
    cur_req = "R12";
    cfg_late_rdy = 1; cfg_rate = 2'd0; tick(2);
    sfd_det = 1; tick(1); sfd_det = 0;
    check("R12", "early ready kept", data_rdy, 1);
    hdr_done = 1; tick(1); hdr_done = 0;
    check("R12", "gated kept in CRC wait", rx_clk_en, 0);
    crc_bad = 1; tick(1); crc_bad = 0;
    rx_en = 0; tick(1);

    // R9 gated transmit clock
    cur_req = "R9";
    set_cfg(0, 0, 2'd0);
    tx_en = 1; tick(3);
    check("R9", "tx_clk_en before tx_ready", tx_clk_en, 0);
    tx_ready = 1; tick(1); tx_ready = 0;
    check("R9", "tx_clk_en after tx_ready", tx_clk_en, 1);
    tick(2);
    check("R9", "tx_clk_en held", tx_clk_en, 1);
    tx_en = 0; tick(1);
    check("R9", "tx_clk_en after tx_en low", tx_clk_en, 0);

    // R10 free running transmit clock
    cur_req = "R10";
    set_cfg(0, 1, 2'd1);
    tx_en = 1; tick(1);
    check("R10", "tx_clk_en after tx_en", tx_clk_en, 1);
    tx_en = 0; tick(1);
    set_cfg(0, 1, 2'd2);
    tx_en = 1; tick(1);
    check("R11", "tx waits for ready at rate 2", tx_clk_en, 0);
    tx_en = 0; tick(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule